// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one memory request per warp and turns it into as few memory transactions as it can. A request carries one 4-byte word address for each of the 32 threads, together with a per-thread active mask. The block groups the active threads by the aligned 128-byte segment their address falls in. It then issues one transaction per distinct segment on a valid/ready output. Each transaction gives the segment base address and the mask of the threads it serves. A fully consecutive, aligned warp costs one transaction. A warp whose threads all land in different segments costs 32.

The control is a three-state machine. In `ST_IDLE` the block is ready for a request. Taking a request with at least one active thread moves it to `ST_ISSUE`. Taking a request with an empty mask moves it straight to `ST_DONE`. In `ST_ISSUE` the block presents the transaction for the lowest-numbered thread that is still pending. When that transaction is accepted, all of its threads are retired. The block stays in `ST_ISSUE` while threads remain, and moves to `ST_DONE` once the accepted transaction retires the last pending thread. `ST_DONE` lasts one cycle, raises `done` with the transaction count, and always returns to `ST_IDLE`.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1, `txn_valid` is 0, `done` is 0 and `done_count` is 0.
- R2: A transaction's `txn_base` equals the address of the threads it serves with bits [6:0] forced to zero. This holds for unaligned words near a segment edge and for the top of the address space.
- R3: When all 32 threads are active and read consecutive words of one aligned 128-byte segment, exactly one transaction is issued, with mask 0xFFFFFFFF.
- R4: One transaction is issued for each distinct segment among the active threads. This ranges up to 32 when every thread sits in its own segment, and `done_count` never exceeds 32.
- R5: Threads whose `req_mask` bit is 0 never appear in any `txn_mask`, and their addresses create no transaction.
- R6: A request with `req_mask` equal to 0 issues no transaction. `done` rises in the first cycle after the request is accepted, with `done_count` equal to 0.
- R7: Transactions come out in ascending order of the lowest-numbered still-pending thread. Each transaction's mask (bit i stands for thread i) holds every pending thread that shares its segment.
- R8: While `txn_valid` is 1 and `txn_ready` is 0, `txn_valid`, `txn_base` and `txn_mask` stay unchanged on the next cycle.
- R9: `req_ready` is 0 from the cycle after a request is accepted until the cycle after `done`. It is never 1 while `txn_valid` is 1.
- R10: `done` is a one-cycle pulse in the cycle after the last transaction handshake, with `done_count` equal to the number of transactions issued. `req_ready` returns to 1 in the following cycle.
- R11: The masks of one request's transactions are nonzero and pairwise disjoint, and together they equal the request's active mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block can take a warp request |
| req_addr | input | 1024 | Thread i byte address in bits [32*i+31 : 32*i] |
| req_mask | input | 32 | Bit i set when thread i is active |
| txn_valid | output | 1 | Transaction presented |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_base | output | 32 | 128-byte-aligned segment base |
| txn_mask | output | 32 | Threads served by this transaction |
| done | output | 1 | One-cycle pulse: request fully issued |
| done_count | output | 6 | Transactions issued for the request, valid with `done` |

## Verification
The hardest situation to reach is a transaction that is held by back-pressure partway through a long request. While the hold lasts, the pending set and the choice of lowest thread must not move, even though many threads in other segments are still waiting. The stimulus gets there by sending a fully scattered 32-segment warp and an interleaved two-segment warp while `txn_ready` is dropped one cycle in three. Every stalled cycle is compared with the one before it, and every accepted transaction is compared against a list the bench builds from the thread addresses. Other cases combine addresses at a segment edge, inactive threads that point at segments of their own, and an empty mask to reach the retire and completion corners.

// File: rtl/coal_pkg.sv
package coal_pkg;

    // Control states of the coalescer
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a warp request
        ST_ISSUE = 2'd1,   // presenting transactions for pending threads
        ST_DONE  = 2'd2    // one-cycle completion report
    } coal_state_e;

endpackage

// File: rtl/coal_leader.sv
// Finds the lowest-numbered pending thread.
module coal_leader #(
    parameter int THREADS = 32,
    localparam int IDX_W  = $clog2(THREADS)
) (
    input  logic [THREADS-1:0] pend,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        // Scan from the top so the lowest set bit wins.
        for (int k = THREADS - 1; k >= 0; k--) begin
            if (pend[k]) begin
                found = 1'b1;
                idx   = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/coal_match.sv
// Builds the segment base of the leading thread and the mask of every
// pending thread that shares it.
module coal_match #(
    parameter int THREADS   = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128,
    localparam int IDX_W     = $clog2(THREADS),
    localparam int SEG_SHIFT = $clog2(SEG_BYTES)
) (
    input  logic [THREADS*ADDR_W-1:0] addr,
    input  logic [THREADS-1:0]        pend,
    input  logic [IDX_W-1:0]          leader_idx,
    output logic [ADDR_W-1:0]         seg_base,
    output logic [THREADS-1:0]        seg_mask
);

    logic [ADDR_W-1:0] seg_id [THREADS];
    logic [ADDR_W-1:0] lead_id;

    // Segment number of each thread
    for (genvar i = 0; i < THREADS; i++) begin : g_seg
        assign seg_id[i] = addr[i*ADDR_W +: ADDR_W] >> SEG_SHIFT;
    end

    // Segment number of the leading thread
    always_comb begin
        lead_id = '0;
        for (int k = 0; k < THREADS; k++) begin
            if (leader_idx == IDX_W'(k)) begin
                lead_id = seg_id[k];
            end
        end
    end

    // Every pending thread in the leader's segment joins the transaction.
    for (genvar i = 0; i < THREADS; i++) begin : g_cmp
        assign seg_mask[i] = pend[i] && (seg_id[i] == lead_id);
    end

    assign seg_base = lead_id << SEG_SHIFT;

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
    parameter int THREADS   = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128,
    localparam int IDX_W     = $clog2(THREADS),
    localparam int CNT_W     = $clog2(THREADS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [THREADS*ADDR_W-1:0]  req_addr,
    input  logic [THREADS-1:0]         req_mask,
    output logic                       txn_valid,
    input  logic                       txn_ready,
    output logic [ADDR_W-1:0]          txn_base,
    output logic [THREADS-1:0]         txn_mask,
    output logic                       done,
    output logic [CNT_W-1:0]           done_count
);

    import coal_pkg::*;

    coal_state_e state_q, state_d;

    logic [THREADS*ADDR_W-1:0] addr_q;
    logic [THREADS-1:0]        pend_q;
    logic [CNT_W-1:0]          cnt_q;

    logic                      lead_found;
    logic [IDX_W-1:0]          lead_idx;
    logic [THREADS-1:0]        grp_mask;
    logic [ADDR_W-1:0]         grp_base;
    logic [THREADS-1:0]        pend_after;

    logic req_take;
    logic txn_take;

    // Lowest pending thread
    coal_leader #(
        .THREADS (THREADS)
    ) i_leader (
        .pend  (pend_q),
        .found (lead_found),
        .idx   (lead_idx)
    );

    // Group of pending threads sharing the leader's segment
    coal_match #(
        .THREADS   (THREADS),
        .ADDR_W    (ADDR_W),
        .SEG_BYTES (SEG_BYTES)
    ) i_match (
        .addr       (addr_q),
        .pend       (pend_q),
        .leader_idx (lead_idx),
        .seg_base   (grp_base),
        .seg_mask   (grp_mask)
    );

    assign req_take   = req_valid && req_ready;
    assign txn_take   = txn_valid && txn_ready;
    assign pend_after = pend_q & ~grp_mask;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_take) begin
                    state_d = (|req_mask) ? ST_ISSUE : ST_DONE;
                end
            end
            ST_ISSUE: begin
                if (txn_take && (pend_after == '0)) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        req_ready = 1'b0;
        txn_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: txn_valid = 1'b1;
            ST_DONE:  done      = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end

    assign txn_base   = grp_base;
    assign txn_mask   = grp_mask;
    assign done_count = cnt_q;

    // Request capture, thread retirement and transaction count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            pend_q <= '0;
            cnt_q  <= '0;
        end else if (req_take) begin
            addr_q <= req_addr;
            pend_q <= req_mask;
            cnt_q  <= '0;
        end else if (txn_take) begin
            pend_q <= pend_after;
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    // A stalled transaction holds its contents.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=>
            (txn_valid && $stable(txn_base) && $stable(txn_mask)));

    // Requests are never taken while a transaction is outstanding.
    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && txn_valid));

    // Accepted threads leave the pending set.
    assert_retire_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready) |=> ((pend_q & $past(txn_mask)) == '0));

    // A presented transaction always serves at least its leading thread.
    assert_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (lead_found && txn_mask[lead_idx]));

    // Completion is one cycle long and hands back to idle.
    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // The count is bounded by the number of threads.
    assert_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_count <= CNT_W'(THREADS)));

endmodule

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 32;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [NT*AW-1:0] req_addr = '0;
    logic [NT-1:0]   req_mask = '0;
    logic            txn_valid;
    logic            txn_ready = 1'b0;
    logic [AW-1:0]   txn_base;
    logic [NT-1:0]   txn_mask;
    logic            done;
    logic [5:0]      done_count;

    int vectors = 0;
    int miscompares = 0;

    // Stimulus storage
    logic [AW-1:0] a [NT];
    logic [NT-1:0] m;

    // Expected transaction list
    logic [AW-1:0] exp_base [NT];
    logic [NT-1:0] exp_mask [NT];
    int            exp_n;

    // Observed results of the last request
    logic [AW-1:0] got_base [NT];
    logic [NT-1:0] got_mask [NT];
    int            got_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_coalescer i_warp_coalescer (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_mask   (req_mask),
        .txn_valid  (txn_valid),
        .txn_ready  (txn_ready),
        .txn_base   (txn_base),
        .txn_mask   (txn_mask),
        .done       (done),
        .done_count (done_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected list built from the requirements: walk threads upward, the
    // first uncovered active thread opens a segment holding all active
    // threads with the same address bits [31:7].
    task automatic build_expect();
        logic [NT-1:0] cov = '0;
        exp_n = 0;
        for (int i = 0; i < NT; i++) begin
            if (m[i] && !cov[i]) begin
                logic [AW-1:0] b = a[i] & ~32'h7F;
                logic [NT-1:0] g = '0;
                for (int j = 0; j < NT; j++) begin
                    if (m[j] && ((a[j] & ~32'h7F) == b)) g[j] = 1'b1;
                end
                cov = cov | g;
                exp_base[exp_n] = b;
                exp_mask[exp_n] = g;
                exp_n++;
            end
        end
    endtask

    // Sends the request in a[]/m, drains it and checks everything.
    task automatic run_req(input bit stall, input string cnt_req);
        int cyc = 0;
        int last_fire = -1;
        bit got_done = 1'b0;
        bit prev_stall = 1'b0;
        logic [AW-1:0] pb = '0;
        logic [NT-1:0] pm = '0;
        logic [NT-1:0] uni = '0;
        logic [NT-1:0] ovl = '0;
        build_expect();
        got_n = 0;
        @(negedge clk);
        for (int w = 0; w < 10 && !req_ready; w++) @(negedge clk);
        check(req_ready == 1'b1, "R9", "ready before request", 64'(req_ready), 64'd1);
        for (int i = 0; i < NT; i++) req_addr[i*AW +: AW] = a[i];
        req_mask  = m;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!got_done && cyc < 300) begin
            txn_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            if (req_ready) check(1'b0, "R9", "ready while busy", 64'd1, 64'd0);
            if (txn_valid) begin
                if (prev_stall) begin
                    check(txn_base == pb, "R8", "base held", 64'(txn_base), 64'(pb));
                    check(txn_mask == pm, "R8", "mask held", 64'(txn_mask), 64'(pm));
                end
                if (txn_ready) begin
                    if (got_n < exp_n) begin
                        check(txn_base == exp_base[got_n], "R7", "txn base",
                              64'(txn_base), 64'(exp_base[got_n]));
                        check(txn_mask == exp_mask[got_n], "R7", "txn mask",
                              64'(txn_mask), 64'(exp_mask[got_n]));
                    end
                    if (got_n < NT) begin
                        got_base[got_n] = txn_base;
                        got_mask[got_n] = txn_mask;
                    end
                    if (txn_mask == '0) check(1'b0, "R11", "empty txn mask", 64'd0, 64'd1);
                    ovl = ovl | (uni & txn_mask);
                    uni = uni | txn_mask;
                    got_n++;
                    last_fire = cyc;
                end
                prev_stall = !txn_ready;
                pb = txn_base;
                pm = txn_mask;
            end else begin
                prev_stall = 1'b0;
            end
            if (done) begin
                got_done = 1'b1;
                check(done_count == 6'(exp_n), "R10", "done_count",
                      64'(done_count), 64'(exp_n));
                check(got_n == exp_n, cnt_req, "transactions issued",
                      64'(got_n), 64'(exp_n));
                check(cyc == last_fire + 1, "R10", "done timing",
                      64'(cyc), 64'(last_fire + 1));
                check(uni == m, "R11", "mask union", 64'(uni), 64'(m));
                check(ovl == '0, "R11", "mask overlap", 64'(ovl), 64'd0);
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        if (!got_done) check(1'b0, "R10", "done never seen", 64'd0, 64'd1);
        txn_ready = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R10", "ready after done", 64'(req_ready), 64'd1);
        check(done == 1'b0, "R10", "done one cycle", 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1", "reset req_ready", 64'(req_ready), 64'd1);
        check(txn_valid == 1'b0, "R1", "reset txn_valid", 64'(txn_valid), 64'd0);
        check(done == 1'b0, "R1", "reset done", 64'(done), 64'd0);
        check(done_count == '0, "R1", "reset done_count", 64'(done_count), 64'd0);
    endtask

    task automatic t_consecutive();
        for (int i = 0; i < NT; i++) a[i] = 32'h0000_1000 + 32'(4 * i);
        m = '1;
        run_req(1'b0, "R3");
        check(got_n == 1, "R3", "single txn", 64'(got_n), 64'd1);
        check(got_mask[0] == '1, "R3", "full mask", 64'(got_mask[0]), 64'hFFFF_FFFF);
    endtask

    task automatic t_scattered(input bit stall);
        for (int i = 0; i < NT; i++) a[i] = 32'h0004_0000 + 32'(128 * (NT - 1 - i)) + 32'(4 * (i % 4));
        m = '1;
        run_req(stall, "R4");
        check(got_n == NT, "R4", "one txn per thread", 64'(got_n), 64'(NT));
    endtask

    task automatic t_two_halves();
        for (int i = 0; i < NT; i++) a[i] = 32'h0000_2000 + 32'(8 * i);
        m = '1;
        run_req(1'b0, "R4");
    endtask

    task automatic t_interleave();
        for (int i = 0; i < NT; i++)
            a[i] = ((i % 2) == 1) ? (32'h0000_2000 + 32'(4 * i)) : (32'h0000_9000 + 32'(4 * i));
        m = '1;
        run_req(1'b1, "R7");
        check(got_base[0] == 32'h0000_9000, "R7", "first base from thread 0",
              64'(got_base[0]), 64'h9000);
        check(got_mask[0] == 32'h5555_5555, "R7", "first group mask",
              64'(got_mask[0]), 64'h5555_5555);
    endtask

    task automatic t_inactive();
        for (int i = 0; i < NT; i++)
            a[i] = (i < 8) ? (32'h0000_3000 + 32'(4 * i)) : (32'h0010_0000 + 32'(256 * i));
        m = 32'h0000_00FF;
        run_req(1'b0, "R5");
        check(got_n == 1, "R5", "inactive threads add nothing", 64'(got_n), 64'd1);
        check((got_mask[0] & ~m) == '0, "R5", "inactive bits clear",
              64'(got_mask[0]), 64'(m));
    endtask

    task automatic t_empty();
        for (int i = 0; i < NT; i++) a[i] = 32'h0000_5000 + 32'(128 * i);
        m = '0;
        run_req(1'b0, "R6");
        check(got_n == 0, "R6", "no txn on empty mask", 64'(got_n), 64'd0);
    endtask

    task automatic t_boundary();
        for (int i = 0; i < NT; i++) a[i] = (i % 2 == 0) ? 32'h0000_107C : 32'h0000_1080;
        a[31] = 32'hFFFF_FFFC;
        m = '1;
        run_req(1'b0, "R2");
        check(got_base[0] == 32'h0000_1000, "R2", "base below edge",
              64'(got_base[0]), 64'h1000);
        check(got_base[1] == 32'h0000_1080, "R2", "base at edge",
              64'(got_base[1]), 64'h1080);
        check(got_base[2] == 32'hFFFF_FF80, "R2", "base at top",
              64'(got_base[2]), 64'hFFFF_FF80);
    endtask

    task automatic t_back_to_back();
        for (int i = 0; i < NT; i++) a[i] = 32'h0000_7000 + 32'(64 * i);
        m = 32'hF0F0_F0F0;
        run_req(1'b0, "R9");
        for (int i = 0; i < NT; i++) a[i] = 32'h0000_7000 + 32'(4 * i);
        m = 32'h8000_0001;
        run_req(1'b1, "R9");
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_consecutive();
        t_scattered(1'b0);
        t_scattered(1'b1);
        t_two_halves();
        t_interleave();
        t_inactive();
        t_empty();
        t_boundary();
        t_back_to_back();
        finish_run();
    end

endmodule